// File: doc/BRIEF.md
# Printer Port Interrupt Controller

This block produces the interrupt output of a parallel printer port controller and the interrupt-related bits that the host sees when it reads the port's status register. A host write to the control register with the kick bit set raises an interrupt request. A board-level strap input picks what clears that request. With the strap low the request is held until the host reads the status register. With the strap high the request drops on the next write to the parallel data port.

A pending flag is also raised by a falling edge on the chosen printer handshake line, either the acknowledge input or the busy input. Both lines are asynchronous and are brought into the clock domain through a synchronizer of configurable depth before the edge is detected. The alternate-function register chooses what drives the interrupt pin. It can be the handshake request, the FIFO empty flag or the FIFO full flag. The same register can invert the pin polarity. A control bit enables the pin driver. When that bit is clear the pin is left in high impedance, and the block reports this through a separate output-enable signal.

Register address decode and the FIFO storage sit outside this block. They reach it as write strobes, a read strobe and two flag inputs.

Top module: `ppic_irq_ctrl`

## Requirements
- R1: After reset, int_oe=0, int_level=1, stat_pend_n=1, stat_b0=1 and stat_live=1 (with ack_n held high), and all control and alternate-function fields read as zero.
- R2: With mode_strap=0 and type 00, a control write with bit 0 set drives int_level to 0 from the next clock edge on. A data port write does not change it. A status read returns it to 1.
- R3: With mode_strap=1 and type 00, a control write with bit 0 set drives int_level to 0. The next data port write returns it to 1.
- R4: stat_pend_n is 0 while the latched flag is set. The flag is set by a kick write, or by a falling edge of the selected handshake line that takes effect SYNC_STAGES+1 clock edges after the input falls. It is cleared by a status read.
- R5: If a status read and a flag-setting event fall in the same cycle, the flag stays set (stat_pend_n=0).
- R6: Alternate-function bit 3 selects the handshake source: 0 selects ack_n and 1 selects busy_in. Falling edges on the unselected line leave stat_pend_n at 1.
- R7: Alternate-function bits 5:4 select the interrupt type. With 00 the pin follows the request chosen by the strap. With 01 or 11 the pin is asserted while fifo_empty=1. With 10 the pin is asserted while fifo_full=1.
- R8: stat_live reports the synchronized ack_n level for type 00, fifo_empty for types 01 and 11, and fifo_full for type 10. A change on ack_n shows on stat_live SYNC_STAGES edges after it occurs.
- R9: stat_b0 is 0 only when the type is 11. Otherwise it is 1.
- R10: int_level is active low (asserted = 0) when alternate-function bit 6 is 0. It is active high when bit 6 is 1.
- R11: int_oe equals bit 4 of the most recent control write.
- R12: A control write with bit 0 clear sets neither the latched flag nor the non-latched request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | 0 selects latched mode, 1 selects non-latched mode |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data: bit 0 kick, bit 4 pin enable |
| alt_wr | input | 1 | Alternate-function register write strobe |
| alt_wdata | input | 8 | Bit 3 source, bits 5:4 type, bit 6 invert |
| data_wr | input | 1 | Parallel data port write strobe |
| stat_rd | input | 1 | Status register read strobe |
| ack_n | input | 1 | Asynchronous acknowledge handshake input |
| busy_in | input | 1 | Asynchronous busy handshake input |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| int_level | output | 1 | Level to be driven on the interrupt pin |
| int_oe | output | 1 | Interrupt pin driver enable |
| stat_live | output | 1 | Status bit 6 value |
| stat_pend_n | output | 1 | Status bit 2 value, 0 = pending |
| stat_b0 | output | 1 | Status bit 0 value |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. A fixed latency of two would hide an off-by-one in the stage chain, and a depth of three exposes it, since edge detection and stat_live timing are checked on the exact edge the parameter predicts. The deeper pipe also leaves room to place a status read on the same edge where a delayed handshake fall takes effect, which is the collision case in R5.

// File: rtl/ppic_pkg.sv
package ppic_pkg;

    localparam int REG_W       = 8;
    localparam int CTL_KICK_B  = 0;
    localparam int CTL_OE_B    = 4;
    localparam int ALT_SRC_B   = 3;
    localparam int ALT_TYPE_LO = 4;
    localparam int ALT_INV_B   = 6;
    localparam int NUM_LINES   = 2;
    localparam int LINE_ACK    = 0;
    localparam int LINE_BUSY   = 1;

    typedef enum logic [1:0] {
        ITYPE_HANDSHAKE = 2'b00,
        ITYPE_EMPTY     = 2'b01,
        ITYPE_FULL      = 2'b10,
        ITYPE_EMPTY_ALT = 2'b11
    } itype_e;

    typedef struct packed {
        logic   invert;
        itype_e itype;
        logic   src_busy;
    } alt_t;

    typedef struct packed {
        logic live;
        logic pend_n;
        logic b0;
    } stat_t;

    function automatic alt_t decode_alt(input logic [REG_W-1:0] w);
        alt_t a;
        a.invert   = w[ALT_INV_B];
        a.itype    = itype_e'(w[ALT_TYPE_LO+1:ALT_TYPE_LO]);
        a.src_busy = w[ALT_SRC_B];
        return a;
    endfunction

    function automatic logic fifo_req(input itype_e t, input logic full, input logic empty);
        logic r;
        case (t)
            ITYPE_FULL:                   r = full;
            ITYPE_EMPTY, ITYPE_EMPTY_ALT: r = empty;
            default:                      r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ppic_hs_sync.sv
module ppic_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign level = chain_q[LAST];
    assign fall  = prev_q & ~chain_q[LAST];

    p_fall_shape_r4: assert property (@(posedge clk) disable iff (rst)
        fall |-> (!level && $past(level)));

endmodule

// File: rtl/ppic_flags.sv
module ppic_flags (
    input  logic clk,
    input  logic rst,
    input  logic kick_wr,
    input  logic data_wr,
    input  logic stat_rd,
    input  logic hs_fall,
    output logic lat_q,
    output logic nl_q
);
    logic lat_set;
    assign lat_set = kick_wr | hs_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= 1'b0;
            nl_q  <= 1'b0;
        end else begin
            if (lat_set)      lat_q <= 1'b1;
            else if (stat_rd) lat_q <= 1'b0;
            if (kick_wr)      nl_q  <= 1'b1;
            else if (data_wr) nl_q  <= 1'b0;
        end
    end

    p_event_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_fall || kick_wr) |=> lat_q);
    p_read_clears_r2: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !hs_fall && !kick_wr) |=> !lat_q);
    p_data_clears_r3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !kick_wr) |=> !nl_q);
    p_kick_sets_r3: assert property (@(posedge clk) disable iff (rst)
        kick_wr |=> nl_q);

endmodule

// File: rtl/ppic_out.sv
module ppic_out
    import ppic_pkg::*;
(
    input  alt_t  alt,
    input  logic  strap,
    input  logic  lat_q,
    input  logic  nl_q,
    input  logic  fifo_full,
    input  logic  fifo_empty,
    input  logic  ack_level,
    output logic  int_level,
    output stat_t stat
);
    logic req;

    always_comb begin
        if (alt.itype == ITYPE_HANDSHAKE) req = strap ? nl_q : lat_q;
        else                              req = fifo_req(alt.itype, fifo_full, fifo_empty);
        int_level = alt.invert ? req : ~req;
    end

    always_comb begin
        case (alt.itype)
            ITYPE_HANDSHAKE: stat.live = ack_level;
            ITYPE_FULL:      stat.live = fifo_full;
            default:         stat.live = fifo_empty;
        endcase
        stat.pend_n = ~lat_q;
        stat.b0     = (alt.itype != ITYPE_EMPTY_ALT);
    end

endmodule

// File: rtl/ppic_irq_ctrl.sv
module ppic_irq_ctrl
    import ppic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_strap,
    input  logic             ctrl_wr,
    input  logic [REG_W-1:0] ctrl_wdata,
    input  logic             alt_wr,
    input  logic [REG_W-1:0] alt_wdata,
    input  logic             data_wr,
    input  logic             stat_rd,
    input  logic             ack_n,
    input  logic             busy_in,
    input  logic             fifo_full,
    input  logic             fifo_empty,
    output logic             int_level,
    output logic             int_oe,
    output logic             stat_live,
    output logic             stat_pend_n,
    output logic             stat_b0
);
    alt_t                 alt_q;
    logic                 oe_q;
    logic                 kick_wr;
    logic [NUM_LINES-1:0] line_in;
    logic [NUM_LINES-1:0] line_lvl;
    logic [NUM_LINES-1:0] line_fall;
    logic                 hs_fall;
    logic                 lat_q;
    logic                 nl_q;
    stat_t                stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            alt_q <= '0;
            oe_q  <= 1'b0;
        end else begin
            if (alt_wr)  alt_q <= decode_alt(alt_wdata);
            if (ctrl_wr) oe_q  <= ctrl_wdata[CTL_OE_B];
        end
    end

    assign kick_wr = ctrl_wr & ctrl_wdata[CTL_KICK_B];

    assign line_in[LINE_ACK]  = ack_n;
    assign line_in[LINE_BUSY] = busy_in;

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            ppic_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst   (rst),
                .din   (line_in[i]),
                .level (line_lvl[i]),
                .fall  (line_fall[i])
            );
        end
    endgenerate

    assign hs_fall = alt_q.src_busy ? line_fall[LINE_BUSY] : line_fall[LINE_ACK];

    ppic_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .kick_wr (kick_wr),
        .data_wr (data_wr),
        .stat_rd (stat_rd),
        .hs_fall (hs_fall),
        .lat_q   (lat_q),
        .nl_q    (nl_q)
    );

    ppic_out u_out (
        .alt        (alt_q),
        .strap      (mode_strap),
        .lat_q      (lat_q),
        .nl_q       (nl_q),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .ack_level  (line_lvl[LINE_ACK]),
        .int_level  (int_level),
        .stat       (stat)
    );

    assign int_oe      = oe_q;
    assign stat_live   = stat.live;
    assign stat_pend_n = stat.pend_n;
    assign stat_b0     = stat.b0;

    p_oe_track_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> (int_oe == $past(ctrl_wdata[CTL_OE_B])));
    p_zero_kick_r12: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_wdata[CTL_KICK_B] && !hs_fall && !lat_q) |=> stat_pend_n);
    p_b0_type_r9: assert property (@(posedge clk) disable iff (rst)
        alt_wr |=> (stat_b0 == !($past(alt_wdata[ALT_TYPE_LO+1:ALT_TYPE_LO]) == 2'b11)));

endmodule

// File: tb/ppic_irq_ctrl_bench.sv
module ppic_irq_ctrl_bench;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_strap = 1'b0;
    logic ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic alt_wr = 1'b0;
    logic [7:0] alt_wdata = '0;
    logic data_wr = 1'b0;
    logic stat_rd = 1'b0;
    logic ack_n = 1'b1;
    logic busy_in = 1'b1;
    logic fifo_full = 1'b0;
    logic fifo_empty = 1'b0;
    logic int_level, int_oe, stat_live, stat_pend_n, stat_b0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppic_irq_ctrl #(.SYNC_STAGES(S)) u_ppic_irq_ctrl (
        .clk(clk), .rst(rst), .mode_strap(mode_strap),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .alt_wr(alt_wr), .alt_wdata(alt_wdata),
        .data_wr(data_wr), .stat_rd(stat_rd),
        .ack_n(ack_n), .busy_in(busy_in),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .int_level(int_level), .int_oe(int_oe),
        .stat_live(stat_live), .stat_pend_n(stat_pend_n), .stat_b0(stat_b0)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr_ctl(input logic oe, input logic kick);
        ctrl_wdata = {3'b000, oe, 3'b000, kick};
        ctrl_wr = 1'b1;
        tick(1);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_alt(input logic inv, input logic [1:0] typ, input logic src);
        alt_wdata = {1'b0, inv, typ, src, 3'b000};
        alt_wr = 1'b1;
        tick(1);
        alt_wr = 1'b0;
    endtask

    task automatic pulse_data();
        data_wr = 1'b1; tick(1); data_wr = 1'b0;
    endtask

    task automatic pulse_read();
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(3); rst = 1'b0; tick(1);
        chk(int_oe, 1'b0, "R1 int_oe after reset");
        chk(int_level, 1'b1, "R1 int_level after reset");
        chk(stat_pend_n, 1'b1, "R1 pend_n after reset");
        chk(stat_b0, 1'b1, "R1 b0 after reset");
        chk(stat_live, 1'b1, "R1 live after reset");
    endtask

    task automatic t_oe();
        wr_ctl(1'b1, 1'b0);
        chk(int_oe, 1'b1, "R11 oe set");
        chk(stat_pend_n, 1'b1, "R12 zero kick leaves pend_n");
        chk(int_level, 1'b1, "R12 zero kick leaves int");
        wr_ctl(1'b0, 1'b0);
        chk(int_oe, 1'b0, "R11 oe cleared");
        wr_ctl(1'b1, 1'b0);
    endtask

    task automatic t_latched();
        mode_strap = 1'b0;
        wr_ctl(1'b1, 1'b1);
        chk(int_level, 1'b0, "R2 kick asserts int");
        chk(stat_pend_n, 1'b0, "R4 kick sets pending");
        pulse_data();
        chk(int_level, 1'b0, "R2 data write ignored in latched mode");
        pulse_read();
        chk(int_level, 1'b1, "R2 read clears int");
        chk(stat_pend_n, 1'b1, "R4 read clears pending");
    endtask

    task automatic t_nonlatched();
        mode_strap = 1'b1;
        wr_ctl(1'b1, 1'b1);
        chk(int_level, 1'b0, "R3 kick asserts int");
        pulse_data();
        chk(int_level, 1'b1, "R3 data write releases int");
        pulse_read();
        mode_strap = 1'b0;
    endtask

    task automatic t_ack_edge();
        ack_n = 1'b0;
        tick(S - 1);
        chk(stat_live, 1'b1, "R8 live before sync delay");
        tick(1);
        chk(stat_live, 1'b0, "R8 live after sync delay");
        chk(stat_pend_n, 1'b1, "R4 not yet pending");
        tick(1);
        chk(stat_pend_n, 1'b0, "R4 pending after ack fall");
        ack_n = 1'b1; tick(S + 2);
        chk(stat_pend_n, 1'b0, "R4 rise does not clear");
        pulse_read();
        chk(stat_pend_n, 1'b1, "R4 read clears");
    endtask

    task automatic t_collision();
        ack_n = 1'b0;
        tick(S);
        stat_rd = 1'b1; tick(1); stat_rd = 1'b0;
        chk(stat_pend_n, 1'b0, "R5 event wins over read");
        ack_n = 1'b1; tick(S + 1);
        pulse_read();
        chk(stat_pend_n, 1'b1, "R5 later read clears");
    endtask

    task automatic t_source();
        wr_alt(1'b0, 2'b00, 1'b1);
        ack_n = 1'b0; tick(S + 2); ack_n = 1'b1; tick(S + 2);
        chk(stat_pend_n, 1'b1, "R6 ack ignored with busy source");
        busy_in = 1'b0; tick(S + 1);
        chk(stat_pend_n, 1'b0, "R6 busy fall sets pending");
        busy_in = 1'b1; tick(S + 1);
        pulse_read();
        wr_alt(1'b0, 2'b00, 1'b0);
        busy_in = 1'b0; tick(S + 2); busy_in = 1'b1; tick(S + 2);
        chk(stat_pend_n, 1'b1, "R6 busy ignored with ack source");
    endtask

    task automatic t_types();
        fifo_empty = 1'b1; fifo_full = 1'b0;
        wr_alt(1'b0, 2'b01, 1'b0);
        chk(int_level, 1'b0, "R7 empty type asserts");
        chk(stat_live, 1'b1, "R8 live shows empty");
        chk(stat_b0, 1'b1, "R9 b0 type 01");
        fifo_empty = 1'b0; tick(1);
        chk(int_level, 1'b1, "R7 empty type releases");
        chk(stat_live, 1'b0, "R8 live follows empty");
        fifo_full = 1'b1;
        wr_alt(1'b0, 2'b10, 1'b0);
        chk(int_level, 1'b0, "R7 full type asserts");
        chk(stat_live, 1'b1, "R8 live shows full");
        fifo_full = 1'b0; fifo_empty = 1'b1;
        wr_alt(1'b0, 2'b11, 1'b0);
        chk(stat_b0, 1'b0, "R9 b0 type 11");
        chk(int_level, 1'b0, "R7 type 11 uses empty");
        fifo_empty = 1'b0;
        wr_alt(1'b0, 2'b00, 1'b0);
        chk(stat_b0, 1'b1, "R9 b0 type 00");
    endtask

    task automatic t_polarity();
        wr_alt(1'b1, 2'b00, 1'b0);
        chk(int_level, 1'b1 ^ 1'b1, "R10 inverted idle");
        wr_ctl(1'b1, 1'b1);
        chk(int_level, 1'b1, "R10 inverted asserted");
        pulse_read();
        wr_alt(1'b0, 2'b00, 1'b0);
        chk(int_level, 1'b1, "R10 normal idle");
    endtask

    initial begin
        tick(1);
        t_reset();
        t_oe();
        t_latched();
        t_nonlatched();
        t_ack_edge();
        t_collision();
        t_source();
        t_types();
        t_polarity();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule